// File: doc/BRIEF.md
# Bouncing Compare Value Sweeper

This block slowly moves two PWM compare values back and forth between programmable bounds. A PWM time base supplies a periodic one-cycle event pulse. The sweeper counts these pulses, and on every qualifying pulse it moves each compare value one step in that value's present direction. Each value turns around when it meets a bound. After every step the block presents both new values together with a one-cycle write strobe, so the PWM can load them into its shadow compare registers.

The two channels are independent. Channel A starts at its lower bound and climbs. Channel B starts at its upper bound and falls. The two reversal tests are deliberately asymmetric. A rising value turns around only when it is stepped while already at its upper bound, and it moves one step down in that same update. A falling value turns around when it is stepped while equal to its lower bound, and it moves one step up. The bounds and the pulse divisor are configuration inputs. They are taken at reset, where the parameter defaults apply, and whenever the sweeper is disabled. Each bound pair must satisfy lower < upper.

Top module: `cmp_sweeper`

## Requirements
- R1: After reset, cmp_a is 200 with a_rising = 1, cmp_b is 1950 with b_rising = 0, and wr_stb is 0. These are the default bounds: A runs from 200 to 1800 and B runs from 50 to 1950, with a pulse divisor of 1.
- R2: An internal pulse counter starts at 0. A tick taken while the counter equals the divisor causes an update and returns the counter to 0. Any other tick only increments the counter. With the default divisor of 1, the values change on every 2nd tick.
- R3: wr_stb is high for exactly the one cycle after the clock edge that took an updating tick, and cmp_a and cmp_b already carry the new values in that cycle. At all other times wr_stb is 0 and both values hold.
- R4: On an update, a rising value that is below its upper bound increments by one and keeps rising.
- R5: On an update, a rising value that equals its upper bound turns to falling and decrements by one in the same update.
- R6: On an update, a falling value that equals its lower bound turns to rising and increments by one. A falling value above its lower bound decrements by one.
- R7: Channels A and B step on the same updates but keep separate bounds and directions. Neither channel's value or direction affects the other.
- R8: While enable is 0, ticks are ignored. The bound and divisor inputs are captured, cmp_a is loaded with a_min (rising), cmp_b is loaded with b_max (falling), and the pulse counter is cleared.
- R9: While enable is 1, changes on a_min, a_max, b_min, b_max and pulse_div have no effect. The captured values stay in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | 1 = sweep; 0 = hold start state and capture configuration |
| tick | input | 1 | One-cycle event pulse from the PWM time base |
| a_min | input | 16 | Lower bound for channel A |
| a_max | input | 16 | Upper bound for channel A |
| b_min | input | 16 | Lower bound for channel B |
| b_max | input | 16 | Upper bound for channel B |
| pulse_div | input | 8 | Counter value at which a tick causes an update |
| wr_stb | output | 1 | One-cycle shadow write strobe |
| cmp_a | output | 16 | Compare value A |
| cmp_b | output | 16 | Compare value B |
| a_rising | output | 1 | Direction of A, 1 = rising |
| b_rising | output | 1 | Direction of B, 1 = rising |

## Verification
Every result is due one clock after the edge that samples the stimulus. This covers an updating tick, a non-updating tick, a configuration capture while disabled, and a change to a configuration input while enabled. The bench drives its inputs at the falling edge. Its reference model advances once for the coming rising edge. The bench then compares all five outputs at the next falling edge, before it applies new inputs. Narrow random bounds and small divisors make reversals at both bounds frequent.

// File: rtl/cmp_sweep_pkg.sv
package cmp_sweep_pkg;
  parameter int CMP_W = 16;
  parameter int CNT_W = 8;

  typedef logic [CMP_W-1:0] cmp_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic rising;
    cmp_t val;
  } step_t;

  // One sweep step: asymmetric turn-around rules.
  function automatic step_t sweep_step(cmp_t v, logic rising, cmp_t lo, cmp_t hi);
    step_t r;
    if (rising) begin
      if (v < hi) begin r.rising = 1'b1; r.val = v + cmp_t'(1); end
      else        begin r.rising = 1'b0; r.val = v - cmp_t'(1); end
    end else begin
      if (v == lo) begin r.rising = 1'b1; r.val = v + cmp_t'(1); end
      else         begin r.rising = 1'b0; r.val = v - cmp_t'(1); end
    end
    return r;
  endfunction

  function automatic logic pulse_due(cnt_t cnt, cnt_t div);
    return cnt == div;
  endfunction
endpackage

// File: rtl/cmp_sweep_div.sv
module cmp_sweep_div
  import cmp_sweep_pkg::*;
#(
  parameter cnt_t DIV_DEF = cnt_t'(1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic tick,
  input  cnt_t div_in,
  output logic upd_evt,
  output cnt_t pcnt,
  output cnt_t div_q
);
  assign upd_evt = enable && tick && pulse_due(pcnt, div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt  <= '0;
      div_q <= DIV_DEF;
    end else if (!enable) begin
      pcnt  <= '0;
      div_q <= div_in;
    end else if (tick) begin
      pcnt <= upd_evt ? '0 : pcnt + cnt_t'(1);
    end
  end
endmodule

// File: rtl/cmp_sweep_chan.sv
module cmp_sweep_chan
  import cmp_sweep_pkg::*;
#(
  parameter cmp_t LO_DEF   = cmp_t'(0),
  parameter cmp_t HI_DEF   = cmp_t'(100),
  parameter bit   START_UP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic upd_evt,
  input  cmp_t lo_in,
  input  cmp_t hi_in,
  output cmp_t val_q,
  output logic rising_q,
  output cmp_t lo_q,
  output cmp_t hi_q
);
  localparam cmp_t START_DEF = START_UP ? LO_DEF : HI_DEF;

  step_t nxt;
  assign nxt = sweep_step(val_q, rising_q, lo_q, hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= LO_DEF;
      hi_q     <= HI_DEF;
      val_q    <= START_DEF;
      rising_q <= START_UP;
    end else if (!enable) begin
      lo_q     <= lo_in;
      hi_q     <= hi_in;
      val_q    <= START_UP ? lo_in : hi_in;
      rising_q <= START_UP;
    end else if (upd_evt) begin
      val_q    <= nxt.val;
      rising_q <= nxt.rising;
    end
  end
endmodule

// File: rtl/cmp_sweeper.sv
module cmp_sweeper
  import cmp_sweep_pkg::*;
#(
  parameter int   W       = CMP_W,
  parameter int   CW      = CNT_W,
  parameter cmp_t A_LO    = cmp_t'(200),
  parameter cmp_t A_HI    = cmp_t'(1800),
  parameter cmp_t B_LO    = cmp_t'(50),
  parameter cmp_t B_HI    = cmp_t'(1950),
  parameter cnt_t DIV_DEF = cnt_t'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic [W-1:0]  a_min,
  input  logic [W-1:0]  a_max,
  input  logic [W-1:0]  b_min,
  input  logic [W-1:0]  b_max,
  input  logic [CW-1:0] pulse_div,
  output logic          wr_stb,
  output logic [W-1:0]  cmp_a,
  output logic [W-1:0]  cmp_b,
  output logic          a_rising,
  output logic          b_rising
);
  localparam int NCH = 2;
  localparam cmp_t [NCH-1:0] LO_TAB = {B_LO, A_LO};
  localparam cmp_t [NCH-1:0] HI_TAB = {B_HI, A_HI};
  localparam bit   [NCH-1:0] UP_TAB = 2'b01;

  logic upd_evt;
  cnt_t pcnt;
  cnt_t div_q;
  cmp_t lo_in  [NCH];
  cmp_t hi_in  [NCH];
  cmp_t val_q  [NCH];
  cmp_t lo_q   [NCH];
  cmp_t hi_q   [NCH];
  logic rise_q [NCH];

  assign lo_in[0] = a_min;
  assign hi_in[0] = a_max;
  assign lo_in[1] = b_min;
  assign hi_in[1] = b_max;

  cmp_sweep_div #(.DIV_DEF(DIV_DEF)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .div_in(pulse_div), .upd_evt(upd_evt), .pcnt(pcnt), .div_q(div_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cmp_sweep_chan #(
      .LO_DEF(LO_TAB[g]), .HI_DEF(HI_TAB[g]), .START_UP(UP_TAB[g])
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .enable(enable), .upd_evt(upd_evt),
      .lo_in(lo_in[g]), .hi_in(hi_in[g]),
      .val_q(val_q[g]), .rising_q(rise_q[g]), .lo_q(lo_q[g]), .hi_q(hi_q[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_stb <= 1'b0;
    else        wr_stb <= upd_evt;
  end

  assign cmp_a    = val_q[0];
  assign cmp_b    = val_q[1];
  assign a_rising = rise_q[0];
  assign b_rising = rise_q[1];
endmodule

module cmp_sweeper_chk
  import cmp_sweep_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick,
  input logic wr_stb,
  input cmp_t cmp_a,
  input cmp_t cmp_b,
  input logic a_rising,
  input logic b_rising,
  input logic upd_evt,
  input cnt_t pcnt,
  input cnt_t div_q,
  input cmp_t a_lo,
  input cmp_t a_hi,
  input cmp_t b_lo,
  input cmp_t b_hi
);
  // R2: the pulse counter never runs past the divisor
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= div_q);
  // R3: a strobe always follows a tick
  p_strobe_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(tick) && $past(enable));
  // R3: values hold when enabled and no update
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !upd_evt) |=> ($stable(cmp_a) && $stable(cmp_b)));
  // R4: an update moves A by exactly one
  p_step_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (cmp_a == $past(cmp_a) + cmp_t'(1) || cmp_a == $past(cmp_a) - cmp_t'(1)));
  // R5: rising at the upper bound turns to falling
  p_turn_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && a_rising && cmp_a == a_hi) |=> (!a_rising && cmp_a == $past(cmp_a) - cmp_t'(1)));
  // R6: falling at the lower bound turns to rising
  p_turn_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !b_rising && cmp_b == b_lo) |=> (b_rising && cmp_b == $past(cmp_b) + cmp_t'(1)));
  // R6/R7: both values stay inside their own bounds
  p_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_a >= a_lo && cmp_a <= a_hi && cmp_b >= b_lo && cmp_b <= b_hi);
  // R8: while disabled no update is produced
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wr_stb);
endmodule

bind cmp_sweeper cmp_sweeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .wr_stb(wr_stb),
  .cmp_a(cmp_a), .cmp_b(cmp_b), .a_rising(a_rising), .b_rising(b_rising),
  .upd_evt(upd_evt), .pcnt(pcnt), .div_q(div_q),
  .a_lo(lo_q[0]), .a_hi(hi_q[0]), .b_lo(lo_q[1]), .b_hi(hi_q[1])
);

// File: tb/cmp_sweeper_tb.sv
module cmp_sweeper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] a_min = 16'd200, a_max = 16'd1800, b_min = 16'd50, b_max = 16'd1950;
  logic [7:0]  pulse_div = 8'd1;
  logic        wr_stb, a_rising, b_rising;
  logic [15:0] cmp_a, cmp_b;

  always #2.5 clk = ~clk;

  cmp_sweeper u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .a_min(a_min), .a_max(a_max), .b_min(b_min), .b_max(b_max),
    .pulse_div(pulse_div), .wr_stb(wr_stb), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .a_rising(a_rising), .b_rising(b_rising)
  );

  int vectors = 0;
  int misses  = 0;

  // reference model state
  int m_a = 200, m_b = 1950, m_alo = 200, m_ahi = 1800, m_blo = 50, m_bhi = 1950;
  int m_div = 1, m_cnt = 0;
  bit m_aup = 1, m_bup = 0, m_stb = 0;
  string tag = "R1";

  // bench restatement of a single step, written as offsets
  function automatic void bounce(inout int v, inout bit up, input int lo, input int hi,
                                 inout string t);
    int delta;
    if (up && v >= hi)        begin up = 0; t = "R5"; end
    else if (!up && v == lo)  begin up = 1; t = "R6"; end
    delta = up ? 1 : -1;
    v = v + delta;
  endfunction

  function automatic void model_edge();
    m_stb = 0;
    if (!enable) begin
      m_alo = a_min; m_ahi = a_max; m_blo = b_min; m_bhi = b_max; m_div = pulse_div;
      m_a = a_min; m_aup = 1; m_b = b_max; m_bup = 0; m_cnt = 0;
      tag = "R8";
    end else if (tick) begin
      if (m_cnt == m_div) begin
        string t = "R4";
        m_cnt = 0; m_stb = 1;
        bounce(m_a, m_aup, m_alo, m_ahi, t);
        bounce(m_b, m_bup, m_blo, m_bhi, t);
        tag = (t == "R4") ? "R3" : t;
      end else begin
        m_cnt++;
        tag = "R2";
      end
    end
  endfunction

  task automatic compare(input string phase);
    vectors++;
    if (wr_stb !== m_stb || cmp_a !== m_a[15:0] || cmp_b !== m_b[15:0] ||
        a_rising !== m_aup || b_rising !== m_bup) begin
      misses++;
      $display("FAIL %s/%s: got stb=%0b a=%0d(%0b) b=%0d(%0b) exp stb=%0b a=%0d(%0b) b=%0d(%0b)",
               phase, tag, wr_stb, cmp_a, a_rising, cmp_b, b_rising,
               m_stb, m_a, m_aup, m_b, m_bup);
    end
  endtask

  // drive one cycle: inputs set at negedge, result checked at next negedge
  task automatic cyc(input bit en, input bit tk, input string phase);
    enable = en; tick = tk;
    model_edge();
    @(negedge clk);
    compare(phase);
  endtask

  task automatic load_cfg(input int alo, input int ahi, input int blo, input int bhi,
                          input int dv, input string phase);
    a_min = alo[15:0]; a_max = ahi[15:0]; b_min = blo[15:0]; b_max = bhi[15:0];
    pulse_div = dv[7:0];
    cyc(0, 1, phase);
    cyc(0, 0, phase);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not complete");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2: default divisor 1, values move on every 2nd tick
    for (int i = 0; i < 8; i++) cyc(1, 1, "R2 default divisor");
    for (int i = 0; i < 3; i++) cyc(1, 0, "R3 idle hold");

    // R9: config changes while enabled are ignored
    a_min = 16'd5; a_max = 16'd7; b_min = 16'd1; b_max = 16'd3; pulse_div = 8'd0;
    for (int i = 0; i < 6; i++) cyc(1, 1, "R9 cfg ignored");

    // R8: disabled capture, ticks ignored
    load_cfg(10, 13, 5, 8, 0, "R8 capture");
    for (int i = 0; i < 4; i++) cyc(0, 1, "R8 ticks ignored");

    // R4 R5 R6 R7: every tick updates, narrow bounds bounce both channels
    for (int i = 0; i < 20; i++) cyc(1, 1, "R5 R6 bounce");

    // R7: different spans so the channels drift out of phase
    load_cfg(100, 102, 40, 47, 2, "R7 setup");
    for (int i = 0; i < 60; i++) cyc(1, i % 2 == 0, "R7 independent");

    // random phase
    for (int blk = 0; blk < 40; blk++) begin
      int alo = $urandom_range(0, 40);
      int blo = $urandom_range(0, 40);
      load_cfg(alo, alo + $urandom_range(1, 6), blo, blo + $urandom_range(1, 6),
               $urandom_range(0, 3), "R8 random cfg");
      for (int i = 0; i < 100; i++) begin
        if ($urandom_range(0, 9) == 0) begin
          a_min = 16'($urandom_range(0, 60)); pulse_div = 8'($urandom_range(0, 5));
        end
        cyc(1, $urandom_range(0, 1) == 1, "R9 random");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule